// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Split Accumulator

This block keeps a 64-bit signed accumulator and updates it from a pair of 32-bit signed operands. Each accepted operation finishes in a single clock. Three operations are available. The first adds the full 64-bit product to the accumulator. The second subtracts the product from it. The third returns a scaled 32-bit result and clears the accumulator.

Software reaches the accumulator as two 32-bit halves through a register-style port. A write replaces one half. A combinational read returns one half. A scaled read-out is the accumulator shifted right arithmetically by a fixed amount of 28 bits, keeping the low 32 bits. It is meant to turn a fixed-point sum of products back into a word-sized value.

Top module: `mac_unit`

## Requirements
- R1: The accumulator is 64 bits wide. `spr_sel`/`spr_rd_sel` = 1 selects bits 63..32 and 0 selects bits 31..0. `spr_rdata` shows the selected half combinationally.
- R2: With `op_valid` high and `op_sel` = 2'b00, the signed 64-bit product of `opnd_a` and `opnd_b` is added to the accumulator at that clock edge.
- R3: With `op_valid` high and `op_sel` = 2'b01, the signed 64-bit product is subtracted from the accumulator at that clock edge.
- R4: With `op_valid` high and `op_sel` = 2'b10, `res_data` takes the accumulator value shifted right by 28, truncated to 32 bits, at that edge. `res_valid` is high for that following cycle, and the accumulator becomes zero at the same edge.
- R5: The read-and-clear shift is arithmetic, so a negative accumulator gives a result whose upper bits are copies of its sign.
- R6: Reset clears both accumulator halves, `res_data` and `res_valid`.
- R7: A write with `spr_we` high replaces only the selected half. Any operation presented in the same cycle is dropped, including its result pulse.
- R8: Operations may be issued on consecutive cycles. Each one sees the result of the previous one.
- R9: The accumulator wraps modulo 2^64 without saturation.
- R10: `op_sel` = 2'b11, or `op_valid` low, leaves the accumulator unchanged and `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 accumulate, 01 subtract, 10 read-and-clear, 11 none |
| opnd_a | input | 32 | Signed operand A |
| opnd_b | input | 32 | Signed operand B |
| spr_we | input | 1 | Write strobe for one accumulator half |
| spr_sel | input | 1 | Half written: 1 high, 0 low |
| spr_wdata | input | 32 | Write data |
| spr_rd_sel | input | 1 | Half read: 1 high, 0 low |
| spr_rdata | output | 32 | Selected half |
| res_data | output | 32 | Scaled read-and-clear result |
| res_valid | output | 1 | One-cycle pulse after read-and-clear |

## Verification
Accumulation is driven with small positive operands, mixed-sign operands and a subtraction that crosses zero. These patterns show whether the product is sign-extended and whether the borrow reaches the high half. Read-and-clear is tried on a positive accumulator whose value straddles the half boundary and on a negative accumulator. Together they separate an arithmetic shift from a logical shift and expose a wrong shift amount. Further cases cover a write colliding with an operation, a sum that steps past the largest positive value, and accumulate followed at once by read-and-clear. These show the write priority, the wrap-around and the single-cycle hazard-free behaviour.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int W     = 32,
  parameter int SCALE = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         spr_we,
  input  logic         spr_sel,
  input  logic [W-1:0] spr_wdata,
  input  logic         spr_rd_sel,
  output logic [W-1:0] spr_rdata,
  output logic [W-1:0] res_data,
  output logic         res_valid
);
  localparam int AW = 2 * W;
  localparam logic [1:0] OP_ACC = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_CLR = 2'b10;

  logic [AW-1:0]        acc_q;
  logic signed [AW-1:0] a_ext, b_ext, prod, acc_sra;

  assign a_ext   = {{W{opnd_a[W-1]}}, opnd_a};
  assign b_ext   = {{W{opnd_b[W-1]}}, opnd_b};
  assign prod    = a_ext * b_ext;
  assign acc_sra = $signed(acc_q) >>> SCALE;

  assign spr_rdata = spr_rd_sel ? acc_q[AW-1:W] : acc_q[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (spr_we) begin
        if (spr_sel) acc_q[AW-1:W] <= spr_wdata;
        else         acc_q[W-1:0]  <= spr_wdata;
      end else if (op_valid) begin
        case (op_sel)
          OP_ACC: acc_q <= acc_q + prod;
          OP_SUB: acc_q <= acc_q - prod;
          OP_CLR: begin
            res_data  <= acc_sra[W-1:0];
            res_valid <= 1'b1;
            acc_q     <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int W     = 32,
  parameter int SCALE = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [1:0]     op_sel,
  input logic [W-1:0]   opnd_a,
  input logic [W-1:0]   opnd_b,
  input logic           spr_we,
  input logic           spr_sel,
  input logic [W-1:0]   spr_wdata,
  input logic [W-1:0]   res_data,
  input logic           res_valid,
  input logic [2*W-1:0] acc
);
  logic signed [2*W-1:0] p_chk, sh_chk;
  logic do_acc, do_sub, do_clr, idle;

  assign p_chk  = $signed({{W{opnd_a[W-1]}}, opnd_a}) * $signed({{W{opnd_b[W-1]}}, opnd_b});
  assign sh_chk = $signed(acc) >>> SCALE;
  assign do_acc = op_valid && op_sel == 2'b00 && !spr_we;
  assign do_sub = op_valid && op_sel == 2'b01 && !spr_we;
  assign do_clr = op_valid && op_sel == 2'b10 && !spr_we;
  assign idle   = (!op_valid || op_sel == 2'b11) && !spr_we;

  AST_MAC_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    do_acc |=> acc == $past(acc) + $past(p_chk)); // R2
  AST_MAC_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    do_sub |=> acc == $past(acc) - $past(p_chk)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> acc == '0 && res_valid); // R4
  AST_CLR_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> res_data == $past(sh_chk[W-1:0])); // R5
  AST_SPR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && !spr_sel) |=> acc[W-1:0] == $past(spr_wdata) && $stable(acc[2*W-1:W]) && !res_valid); // R7
  AST_SPR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_we && spr_sel) |=> acc[2*W-1:W] == $past(spr_wdata) && $stable(acc[W-1:0]) && !res_valid); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(acc) && !res_valid); // R10
endmodule

bind mac_unit mac_unit_chk #(.W(W), .SCALE(SCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .spr_we(spr_we), .spr_sel(spr_sel),
  .spr_wdata(spr_wdata), .res_data(res_data), .res_valid(res_valid),
  .acc(acc_q)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'b11;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        spr_we = 1'b0, spr_sel = 1'b0, spr_rd_sel = 1'b0;
  logic [31:0] spr_wdata = '0;
  logic [31:0] spr_rdata, res_data;
  logic        res_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .spr_we(spr_we), .spr_sel(spr_sel),
    .spr_wdata(spr_wdata), .spr_rd_sel(spr_rd_sel), .spr_rdata(spr_rdata),
    .res_data(res_data), .res_valid(res_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    spr_rd_sel = sel;
    #1 v = spr_rdata;
  endtask

  task automatic chk_acc(input string tag, input logic [63:0] exp);
    logic [31:0] v;
    rd(1'b1, v); chk({tag, " high"}, v, exp[63:32]);
    rd(1'b0, v); chk({tag, " low"}, v, exp[31:0]);
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic we, input logic sel, input logic [31:0] wd);
    @(negedge clk);
    op_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    spr_we = we; spr_sel = sel; spr_wdata = wd;
    @(posedge clk); #1;
    op_valid = 1'b0; op_sel = 2'b11; spr_we = 1'b0;
  endtask

  task automatic load(input logic [63:0] v);
    step(1'b0, 2'b11, 0, 0, 1'b1, 1'b1, v[63:32]);
    step(1'b0, 2'b11, 0, 0, 1'b1, 1'b0, v[31:0]);
  endtask

  task automatic t_reset;
    chk_acc("R6 reset acc", 64'd0);
    chk("R6 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R6 reset res_data", res_data, 32'd0);
  endtask

  task automatic t_accumulate;
    step(1'b1, 2'b00, 32'd3, 32'd5, 1'b0, 1'b0, 0);
    chk_acc("R2 3*5", 64'd15);
    step(1'b1, 2'b00, -32'sd7, 32'd6, 1'b0, 1'b0, 0);
    chk_acc("R2 R1 signed -42", 64'hFFFF_FFFF_FFFF_FFE5);
  endtask

  task automatic t_subtract;
    step(1'b1, 2'b01, -32'sd4, -32'sd5, 1'b0, 1'b0, 0);
    chk_acc("R3 sub 20", 64'hFFFF_FFFF_FFFF_FFD1);
    step(1'b1, 2'b01, 32'd10, -32'sd10, 1'b0, 1'b0, 0);
    chk_acc("R3 sub -100", 64'd53);
  endtask

  task automatic t_clear_pos;
    load(64'h0000_0001_2000_0000);
    chk_acc("R1 write halves", 64'h0000_0001_2000_0000);
    step(1'b1, 2'b10, 0, 0, 1'b0, 1'b0, 0);
    chk("R4 res_data", res_data, 32'h0000_0012);
    chk("R4 res_valid", {31'd0, res_valid}, 32'd1);
    chk_acc("R4 cleared", 64'd0);
    @(posedge clk); #1;
    chk("R4 pulse ends", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_clear_neg;
    load(64'hFFFF_FFFF_0000_0000);
    step(1'b1, 2'b10, 0, 0, 1'b0, 1'b0, 0);
    chk("R5 arithmetic shift", res_data, 32'hFFFF_FFF0);
    load(64'h8000_0000_0000_0000);
    step(1'b1, 2'b10, 0, 0, 1'b0, 1'b0, 0);
    chk("R5 min value", res_data, 32'h0000_0000);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    op_valid = 1'b1; op_sel = 2'b00; opnd_a = 32'h1000_0000; opnd_b = 32'h10;
    @(posedge clk); #1;
    @(negedge clk);
    op_sel = 2'b10;
    @(posedge clk); #1;
    op_valid = 1'b0; op_sel = 2'b11;
    chk("R8 clear after mac", res_data, 32'h0000_0010);
    chk_acc("R8 acc zero", 64'd0);
  endtask

  task automatic t_priority;
    load(64'h0000_0005_0000_0007);
    step(1'b1, 2'b00, 32'd100, 32'd100, 1'b1, 1'b0, 32'hABCD_0001);
    chk_acc("R7 low write wins", 64'h0000_0005_ABCD_0001);
    step(1'b1, 2'b10, 0, 0, 1'b1, 1'b1, 32'h0000_0009);
    chk("R7 clear dropped", {31'd0, res_valid}, 32'd0);
    chk_acc("R7 high write wins", 64'h0000_0009_ABCD_0001);
  endtask

  task automatic t_wrap;
    load(64'h7FFF_FFFF_FFFF_FFFF);
    step(1'b1, 2'b00, 32'd1, 32'd1, 1'b0, 1'b0, 0);
    chk_acc("R9 wrap up", 64'h8000_0000_0000_0000);
    step(1'b1, 2'b01, 32'd1, 32'd1, 1'b0, 1'b0, 0);
    chk_acc("R9 wrap down", 64'h7FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_no_op;
    load(64'h1234_5678_9ABC_DEF0);
    step(1'b1, 2'b11, 32'd9, 32'd9, 1'b0, 1'b0, 0);
    chk_acc("R10 reserved op", 64'h1234_5678_9ABC_DEF0);
    chk("R10 no pulse", {31'd0, res_valid}, 32'd0);
    step(1'b0, 2'b00, 32'd9, 32'd9, 1'b0, 1'b0, 0);
    chk_acc("R10 valid low", 64'h1234_5678_9ABC_DEF0);
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_accumulate;
    t_subtract;
    t_clear_pos;
    t_clear_neg;
    t_back_to_back;
    t_priority;
    t_wrap;
    t_no_op;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule